// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Engine

This block sits beside one single-port synchronous SRAM and can test every cell of it without outside help. While idle it passes the functional enable, write-enable, address and write data straight through to the memory. A rising edge on the test enable starts a run. The engine then takes the memory ports and walks through one of two March sequences, chosen by a select line that is sampled once at the start. Each sequence is a list of elements. Every element has an address direction and one or two read/write operations, which are applied at each address before the address steps.

Every read is compared with the all-zeros or all-ones word the sequence expects. Each mismatch is streamed out as a one-cycle report that carries the address and a per-bit difference mask. At the end of the run a done pulse is issued together with a pass flag. A sticky fail flag records whether any mismatch occurred, until the next run starts. The memory has one cycle of read latency. The address and expected value are delayed by one stage so that they meet the returned word.

Top module: `march_selftest`

## Requirements
- R1: During and straight after reset, testBusy, testDone, testPass, stickyFail and failValid are all 0.
- R2: While not busy, memEn, memWe, memAddr and memWrData equal funcEn, funcWe, funcAddr and funcWrData. While busy, the functional inputs have no effect on the memory ports.
- R3: A run starts at the clock edge that first sees testEn high after it was low, provided the engine is idle. testBusy is 1 from the next cycle on. Holding testEn high after the run ends does not start another run.
- R4: With algoSel=0 the engine performs, one operation per cycle, up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0), which is 10N operations for N=2^ADDR_W. Cycle 1 after the starting edge is an init cycle with memEn=0. Operations occupy cycles 2 to 10N+1, and testDone is high in cycle 10N+3. A write of w0 drives an all-zeros word and w1 drives an all-ones word, each with memWe=1. A read is issued with memWe=0.
- R5: With algoSel=1 the engine performs up(w0); up(r0,w1); down(r1,w0); up(r0,w1); down(r1,w0); up(r0,w1); down(r1,w0); up(r0), which is 14N operations, with the same cycle layout (testDone in cycle 14N+3).
- R6: An ascending element visits addresses 0 to N-1 and a descending element visits N-1 to 0. All operations of an element are done at one address before the address moves on.
- R7: A read issued in cycle c whose returned word differs from the expected word gives failValid=1 in cycle c+2 only. In that cycle failAddr is the read address and failMask is the returned word XOR the expected word.
- R8: testDone is a one-cycle pulse. testPass is 1 from that pulse until the next start exactly when no read in the run mismatched. stickyFail is set by the first mismatch, holds, and is cleared at the next start.
- R9: On a fault-free memory both sequences end with testPass=1 and no fail reports.
- R10: algoSel is sampled only at the start edge. Changing it during a run does not change the operation sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| testEn | input | 1 | Rising edge starts a self-test run |
| algoSel | input | 1 | Sequence choice: 0 = 10N sequence, 1 = 14N sequence |
| funcEn | input | 1 | Functional memory enable |
| funcWe | input | 1 | Functional write enable |
| funcAddr | input | ADDR_W | Functional address |
| funcWrData | input | DATA_W | Functional write data |
| memEn | output | 1 | Memory enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Memory read data, one cycle after a read |
| testBusy | output | 1 | Engine owns the memory |
| testDone | output | 1 | One-cycle end-of-run pulse |
| testPass | output | 1 | Run had no mismatch |
| stickyFail | output | 1 | A mismatch has occurred in this run |
| failValid | output | 1 | Fail report valid |
| failAddr | output | ADDR_W | Address of the failing read |
| failMask | output | DATA_W | Per-bit mismatch mask |

## Verification
The bench places its own behavioural SRAM at the memory ports and injects stuck-at, transition and inversion-coupling faults into it. For each run it computes the exact operation trace and the list of fail reports from a separate model of both sequences. Faults at address 0 and N-1 and couplings in both address directions are included, so a direction swap or an off-by-one at the end of an element changes the reported address or the cycle of the report. A compare stage that is misaligned by one cycle shows up as reports arriving in the wrong cycle or with the wrong mask. A sticky flag that is not cleared at start makes the fault-free run that follows a faulty one fail. Changing the select line in the middle of a run exposes an engine that reads it live, because the 14N trace diverges.

// File: rtl/march_selftest_pkg.sv
package march_selftest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_UP,
    ST_DOWN,
    ST_DONE
  } stateT;

  // bit 1 = write, bit 0 = data background value
  typedef enum logic [1:0] {
    OP_R0 = 2'b00,
    OP_R1 = 2'b01,
    OP_W0 = 2'b10,
    OP_W1 = 2'b11
  } opT;

  typedef struct packed {
    logic descend;
    logic twoOps;
    opT   first;
    opT   second;
  } elemT;

  // control -> datapath strobes
  typedef struct packed {
    logic opValid;
    logic opWrite;
    logic opBit;
    logic addrLoadLo;
    logic addrLoadHi;
    logic addrUp;
    logic addrDown;
    logic runStart;
    logic runFinish;
  } strobeT;

  function automatic logic [2:0] lastElemIdx(input logic longSeq);
    return longSeq ? 3'd7 : 3'd5;
  endfunction

  // Element table for both sequences, computed from the index.
  // Short sequence: directions U U U D D U. Long one: U U D U D U D U.
  // Inner elements alternate (r0,w1) on odd and (r1,w0) on even indices.
  function automatic elemT marchElem(input logic longSeq, input logic [2:0] idx);
    elemT e;
    e.descend = 1'b0;
    e.twoOps  = 1'b0;
    e.first   = OP_W0;
    e.second  = OP_W0;
    if (idx == 3'd0) begin
      e.first = OP_W0;
    end else if (idx == lastElemIdx(longSeq)) begin
      e.first = OP_R0;
    end else begin
      e.twoOps  = 1'b1;
      e.descend = longSeq ? ~idx[0] : (idx >= 3'd3);
      if (idx[0]) begin
        e.first  = OP_R0;
        e.second = OP_W1;
      end else begin
        e.first  = OP_R1;
        e.second = OP_W0;
      end
    end
    return e;
  endfunction

endpackage

// File: rtl/march_selftest_ctrl.sv
module march_selftest_ctrl
  import march_selftest_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   testEn,
  input  logic   algoSel,
  input  logic   addrAtMin,
  input  logic   addrAtMax,
  output strobeT strb,
  output logic   busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 4;

  stateT      state, stateNx;
  logic       algoQ;
  logic [2:0] elemIdx;
  logic       opSecond;
  logic       testEnQ;

  elemT curElem, nxtElem;
  opT   curOp;
  logic lastOp, atEnd, isLastElem;

  assign curElem    = marchElem(algoQ, elemIdx);
  assign nxtElem    = marchElem(algoQ, elemIdx + 3'd1);
  assign curOp      = opSecond ? curElem.second : curElem.first;
  assign lastOp     = !curElem.twoOps || opSecond;
  assign atEnd      = curElem.descend ? addrAtMin : addrAtMax;
  assign isLastElem = (elemIdx == lastElemIdx(algoQ));
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strb    = '0;
    stateNx = state;
    case (state)
      ST_IDLE: begin
        if (testEn && !testEnQ) begin
          strb.runStart = 1'b1;
          stateNx       = ST_INIT;
        end
      end
      ST_INIT: begin
        strb.addrLoadHi = curElem.descend;
        strb.addrLoadLo = !curElem.descend;
        stateNx         = curElem.descend ? ST_DOWN : ST_UP;
      end
      ST_UP, ST_DOWN: begin
        strb.opValid = 1'b1;
        strb.opWrite = curOp[1];
        strb.opBit   = curOp[0];
        if (lastOp) begin
          if (!atEnd) begin
            strb.addrUp   = !curElem.descend;
            strb.addrDown = curElem.descend;
          end else if (isLastElem) begin
            stateNx = ST_DONE;
          end else begin
            strb.addrLoadHi = nxtElem.descend;
            strb.addrLoadLo = !nxtElem.descend;
            stateNx         = nxtElem.descend ? ST_DOWN : ST_UP;
          end
        end
      end
      ST_DONE: begin
        strb.runFinish = 1'b1;
        stateNx        = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      algoQ    <= 1'b0;
      elemIdx  <= 3'd0;
      opSecond <= 1'b0;
      testEnQ  <= 1'b0;
    end else begin
      testEnQ <= testEn;
      state   <= stateNx;
      if (strb.runStart) begin
        algoQ    <= algoSel;
        elemIdx  <= 3'd0;
        opSecond <= 1'b0;
      end else if (strb.opValid) begin
        if (!lastOp) begin
          opSecond <= 1'b1;
        end else begin
          opSecond <= 1'b0;
          if (atEnd && !isLastElem) elemIdx <= elemIdx + 3'd1;
        end
      end
    end
  end

  // operation counter kept for the run-length check
  logic [CNT_W-1:0] opCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             opCount <= '0;
    else if (strb.runStart) opCount <= '0;
    else if (strb.opValid)  opCount <= opCount + 1'b1;
  end

  // R4 (short sequence) and R5 (long sequence): run length in operations
  assert_op_total_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |->
      (opCount == (algoQ ? CNT_W'(14 * DEPTH) : CNT_W'(10 * DEPTH))));

  assert_one_addr_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.addrLoadLo, strb.addrLoadHi, strb.addrUp, strb.addrDown}));

  assert_done_to_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> !busy);

endmodule

// File: rtl/march_selftest_dp.sv
module march_selftest_dp
  import march_selftest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  strobeT            strb,
  input  logic              funcEn,
  input  logic              funcWe,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWrData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              addrAtMin,
  output logic              addrAtMax,
  output logic              failValid,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failMask,
  output logic              stickyFail,
  output logic              testDone,
  output logic              testPass
);

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addrQ;
  logic              rdPendQ;
  logic              expBitQ;
  logic [DATA_W-1:0] expWord;
  logic              mismatch;

  // address generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addr <= '0;
    else if (strb.addrLoadLo) addr <= '0;
    else if (strb.addrLoadHi) addr <= '1;
    else if (strb.addrUp)     addr <= addr + 1'b1;
    else if (strb.addrDown)   addr <= addr - 1'b1;
  end

  assign addrAtMin = (addr == '0);
  assign addrAtMax = (addr == '1);

  // memory input multiplexer
  assign memEn     = busy ? strb.opValid : funcEn;
  assign memWe     = busy ? strb.opWrite : funcWe;
  assign memAddr   = busy ? addr : funcAddr;
  assign memWrData = busy ? {DATA_W{strb.opBit}} : funcWrData;

  // one-stage alignment with the memory read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      expBitQ <= 1'b0;
      addrQ   <= '0;
    end else begin
      rdPendQ <= strb.opValid && !strb.opWrite;
      expBitQ <= strb.opBit;
      addrQ   <= addr;
    end
  end

  assign expWord  = {DATA_W{expBitQ}};
  assign mismatch = rdPendQ && (memRdData != expWord);

  // response analyser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failValid  <= 1'b0;
      failAddr   <= '0;
      failMask   <= '0;
      stickyFail <= 1'b0;
      testDone   <= 1'b0;
      testPass   <= 1'b0;
    end else begin
      failValid <= mismatch;
      if (mismatch) begin
        failAddr <= addrQ;
        failMask <= memRdData ^ expWord;
      end
      if (strb.runStart)  stickyFail <= 1'b0;
      else if (mismatch)  stickyFail <= 1'b1;
      testDone <= strb.runFinish;
      if (strb.runStart)       testPass <= 1'b0;
      else if (strb.runFinish) testPass <= !(stickyFail || mismatch);
    end
  end

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrUp |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  assert_fail_in_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    failValid |-> $past(busy, 2));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    testDone |=> !testDone);

endmodule

// File: rtl/march_selftest.sv
module march_selftest
  import march_selftest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              algoSel,
  input  logic              funcEn,
  input  logic              funcWe,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWrData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              testBusy,
  output logic              testDone,
  output logic              testPass,
  output logic              stickyFail,
  output logic              failValid,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failMask
);

  strobeT strb;
  logic   busy;
  logic   addrAtMin, addrAtMax;

  assign testBusy = busy;

  march_selftest_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .testEn    (testEn),
    .algoSel   (algoSel),
    .addrAtMin (addrAtMin),
    .addrAtMax (addrAtMax),
    .strb      (strb),
    .busy      (busy)
  );

  march_selftest_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .strb       (strb),
    .funcEn     (funcEn),
    .funcWe     (funcWe),
    .funcAddr   (funcAddr),
    .funcWrData (funcWrData),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memRdData  (memRdData),
    .addrAtMin  (addrAtMin),
    .addrAtMax  (addrAtMax),
    .failValid  (failValid),
    .failAddr   (failAddr),
    .failMask   (failMask),
    .stickyFail (stickyFail),
    .testDone   (testDone),
    .testPass   (testPass)
  );

endmodule

// File: tb/march_selftest_bench.sv
module march_selftest_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN = 1'b0;
  logic          testEn = 1'b0, algoSel = 1'b0;
  logic          funcEn = 1'b0, funcWe = 1'b0;
  logic [AW-1:0] funcAddr = '0;
  logic [DW-1:0] funcWrData = '0;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData = '0;
  logic          testBusy, testDone, testPass, stickyFail, failValid;
  logic [AW-1:0] failAddr;
  logic [DW-1:0] failMask;

  march_selftest #(.ADDR_W(AW), .DATA_W(DW)) u_march_selftest (
    .clk(clk), .rstN(rstN), .testEn(testEn), .algoSel(algoSel),
    .funcEn(funcEn), .funcWe(funcWe), .funcAddr(funcAddr), .funcWrData(funcWrData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .testBusy(testBusy), .testDone(testDone),
    .testPass(testPass), .stickyFail(stickyFail), .failValid(failValid),
    .failAddr(failAddr), .failMask(failMask)
  );

  // fault configuration: 0 none, 1 stuck-at, 2 transition, 3 inversion coupling
  int   faultKind = 0, fAddr = 0, fBit = 0, aggAddr = 0;
  logic fVal = 1'b0;

  function automatic logic [DW-1:0] faultyRead(input logic [DW-1:0] v, input int a);
    logic [DW-1:0] r = v;
    if (faultKind == 1 && a == fAddr) r[fBit] = fVal;
    return r;
  endfunction

  function automatic logic [DW-1:0] faultyStore(input logic [DW-1:0] old,
                                                input logic [DW-1:0] d, input int a);
    logic [DW-1:0] r = d;
    if (faultKind == 2 && a == fAddr && old[fBit] != fVal && d[fBit] == fVal)
      r[fBit] = old[fBit];
    return r;
  endfunction

  function automatic bit couples(input logic [DW-1:0] old, input logic [DW-1:0] d, input int a);
    return (faultKind == 3) && (a == aggAddr) && !old[fBit] && d[fBit];
  endfunction

  // behavioural SRAM, one-cycle read latency
  logic [DW-1:0] sramMem [DEPTH];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        if (couples(sramMem[memAddr], memWrData, int'(memAddr)))
          sramMem[fAddr][fBit] <= ~sramMem[fAddr][fBit];
        sramMem[memAddr] <= faultyStore(sramMem[memAddr], memWrData, int'(memAddr));
      end else begin
        memRdData <= faultyRead(sramMem[memAddr], int'(memAddr));
      end
    end
  end

  // independent bench model
  logic [DW-1:0] modelMem [DEPTH];
  int opA[$], opC[$];          // op code: 0 r0, 1 r1, 2 w0, 3 w1
  int efIdx[$], efAddr[$], efMask[$];
  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic elemInfo(input bit lr, input int e, output bit down, output int cnt,
                          output int o0, output int o1);
    int last = lr ? 7 : 5;
    down = 0; cnt = 1; o0 = 2; o1 = 0;
    if (e == 0) o0 = 2;
    else if (e == last) o0 = 0;
    else begin
      cnt  = 2;
      down = lr ? ((e % 2) == 0) : (e >= 3);
      if (e % 2 == 1) begin o0 = 0; o1 = 3; end
      else begin o0 = 1; o1 = 2; end
    end
  endtask

  task automatic buildAndModel(input bit lr);
    opA.delete(); opC.delete(); efIdx.delete(); efAddr.delete(); efMask.delete();
    for (int e = 0; e < (lr ? 8 : 6); e++) begin
      bit down; int cnt, o0, o1;
      elemInfo(lr, e, down, cnt, o0, o1);
      for (int k = 0; k < DEPTH; k++) begin
        int a = down ? DEPTH - 1 - k : k;
        for (int o = 0; o < cnt; o++) begin
          opA.push_back(a);
          opC.push_back(o == 0 ? o0 : o1);
        end
      end
    end
    for (int i = 0; i < opA.size(); i++) begin
      int a = opA[i];
      logic [DW-1:0] w = {DW{opC[i][0]}};
      if (opC[i] >= 2) begin
        if (couples(modelMem[a], w, a)) modelMem[fAddr][fBit] = ~modelMem[fAddr][fBit];
        modelMem[a] = faultyStore(modelMem[a], w, a);
      end else begin
        logic [DW-1:0] rv = faultyRead(modelMem[a], a);
        if (rv != w) begin
          efIdx.push_back(i); efAddr.push_back(a); efMask.push_back(int'(rv ^ w));
        end
      end
    end
  endtask

  task automatic runMarch(input bit lr, input int kind, input int fa, input int fb,
                          input logic fv, input int agg, input bit flipSel);
    string rq = lr ? "R5" : "R4";
    int gotCyc[$], gotAddr[$], gotMask[$];
    int traceErr = 0, doneCyc = 0, nOps;
    faultKind = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] v = DW'($urandom);
      funcEn = 1; funcWe = 1; funcAddr = AW'(a); funcWrData = v;
      modelMem[a] = v;
      @(negedge clk);
    end
    funcEn = 0; funcWe = 0;
    faultKind = kind; fAddr = fa; fBit = fb; fVal = fv; aggAddr = agg;
    buildAndModel(lr);
    nOps = opA.size();
    testEn = 1; algoSel = lr;
    for (int cyc = 1; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        check(testBusy == 1, "R3", "busy after start", testBusy, 1);
        check(memEn == 0, rq, "init cycle memEn", memEn, 0);
        check(stickyFail == 0, "R8", "sticky cleared at start", stickyFail, 0);
      end else if (cyc - 2 < nOps) begin
        int i = cyc - 2;
        bit ok = memEn && (memWe == (opC[i] >= 2)) && (int'(memAddr) == opA[i]);
        if (opC[i] >= 2 && memWrData != {DW{opC[i][0]}}) ok = 0;
        if (!ok) begin
          if (traceErr == 0)
            $display("FAIL %s/R6 op %0d addr actual=%0d expected=%0d we actual=%0d",
                     rq, i, memAddr, opA[i], memWe);
          traceErr++;
        end
      end
      if (failValid) begin
        gotCyc.push_back(cyc); gotAddr.push_back(int'(failAddr)); gotMask.push_back(int'(failMask));
      end
      if (testDone) begin doneCyc = cyc; break; end
      // functional traffic and select changes during the run must not matter (R2, R10)
      funcEn = 1; funcWe = 1'($urandom); funcAddr = AW'($urandom); funcWrData = DW'($urandom);
      if (flipSel && cyc == 40) algoSel = ~lr;
    end
    funcEn = 0; funcWe = 0;
    total++;
    if (traceErr != 0) bad++;
    if (flipSel) check(traceErr == 0, "R10", "trace with select flipped, mismatches", traceErr, 0);
    else check(traceErr == 0, "R2", "trace while busy, mismatches", traceErr, 0);
    check(doneCyc == nOps + 3, rq, "done cycle", doneCyc, nOps + 3);
    check(gotCyc.size() == efIdx.size(), "R7", "fail report count", gotCyc.size(), efIdx.size());
    for (int j = 0; j < gotCyc.size() && j < efIdx.size(); j++) begin
      check(gotCyc[j] == efIdx[j] + 4, "R7", "fail report cycle", gotCyc[j], efIdx[j] + 4);
      check(gotAddr[j] == efAddr[j], "R7", "fail address", gotAddr[j], efAddr[j]);
      check(gotMask[j] == efMask[j], "R7", "fail mask", gotMask[j], efMask[j]);
    end
    if (efIdx.size() == 0)
      check(testPass == 1, "R9", "pass on clean run", testPass, 1);
    else
      check(testPass == 0, "R8", "pass flag on faulty run", testPass, 0);
    check(stickyFail == (efIdx.size() != 0), "R8", "sticky flag", stickyFail, efIdx.size() != 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(testDone == 0, "R8", "done is a single pulse", testDone, 0);
      check(testBusy == 0, "R3", "no restart while enable held", testBusy, 0);
    end
    check(testPass == (efIdx.size() == 0), "R8", "pass flag held", testPass, efIdx.size() == 0);
    testEn = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    check(testBusy == 0 && testDone == 0 && testPass == 0 && stickyFail == 0 && failValid == 0,
          "R1", "outputs in reset", {testBusy, testDone, testPass, stickyFail, failValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(testBusy == 0 && testDone == 0 && testPass == 0 && stickyFail == 0 && failValid == 0,
          "R1", "outputs after reset", {testBusy, testDone, testPass, stickyFail, failValid}, 0);
    // R2: idle pass-through under random functional traffic
    for (int n = 0; n < 16; n++) begin
      funcEn = 1'($urandom); funcWe = 1'($urandom);
      funcAddr = AW'($urandom); funcWrData = DW'($urandom);
      #1;
      check(memEn == funcEn && memWe == funcWe && memAddr == funcAddr && memWrData == funcWrData,
            "R2", "idle pass-through addr", memAddr, funcAddr);
      @(negedge clk);
    end
    funcEn = 0;
    // directed corners
    runMarch(0, 0, 0, 0, 0, 1, 0);           // clean, short sequence
    runMarch(1, 0, 0, 0, 0, 1, 0);           // clean, long sequence
    runMarch(0, 1, 5, 3, 0, 0, 0);           // stuck-at-0
    runMarch(1, 1, 0, 7, 1, 1, 0);           // stuck-at-1 at lowest address
    runMarch(0, 2, 15, 0, 1, 0, 0);          // cannot rise at top address
    runMarch(1, 2, 8, 4, 0, 0, 0);           // cannot fall
    runMarch(0, 3, 9, 2, 0, 3, 0);           // coupling, aggressor below victim
    runMarch(1, 3, 2, 6, 0, 12, 0);          // coupling, aggressor above victim
    runMarch(0, 0, 0, 0, 0, 1, 0);           // clean after faulty: sticky cleared
    runMarch(1, 0, 0, 0, 0, 1, 1);           // select flipped mid-run
    runMarch(0, 1, 4, 1, 1, 0, 1);           // short sequence, select flipped
    // constrained random faults
    for (int n = 0; n < 6; n++) begin
      int fa = $urandom_range(0, DEPTH - 1);
      int ag = (fa + 1 + $urandom_range(0, DEPTH - 2)) % DEPTH;
      runMarch(1'($urandom), $urandom_range(0, 3), fa, $urandom_range(0, DW - 1),
               1'($urandom), ag, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule